// File: doc/BRIEF.md
# Recursive Parallel Prefix Network

This block takes a vector of N elements, each W bits wide, and returns every prefix combination of that vector under one associative binary operator. Output element i is the combination of input elements i, i-1, down to 0. Higher-indexed operands always sit on the left of the operator. The whole path is combinational, so the outputs follow the inputs within the same cycle. The block is meant to sit inside larger datapaths such as reductions, running parity or running sums.

The network is built by divide and conquer. Each adjacent pair of inputs is first merged, with the odd element as the left operand. The same network then solves the prefix problem on the half-length vector. The odd-indexed outputs are copied from that half-size result. Each even-indexed output above zero takes one extra operator: the even input combined with the preceding half-size result. When N is odd, the network is built for N-1 elements and one more operator is placed on the top element. The recursion stops at a single element, which is passed straight through.

A parameter picks the operator. Because every operator instance keeps its operand order, an operator that is associative but not commutative still gives the right prefixes.

Top module: `ppn_top`

## Requirements
- R1: For every i in 0..N-1, y_out[i] equals x_in[i] ∘ x_in[i-1] ∘ … ∘ x_in[0], evaluated as a left-nested fold over the inputs, for any N of at least 1.
- R2: y_out[0] equals x_in[0] unchanged, for every operator.
- R3: Operand order is preserved. With operator code 4 (keep-left, a∘b = a), every output y_out[i] equals x_in[i].
- R4: An odd N gives correct prefixes on every output, including the top output y_out[N-1].
- R5: With N = 1, the output equals the input.
- R6: Operator code 3 is addition modulo 2^W. Carries beyond bit W-1 are dropped.
- R7: Operator codes 0, 1 and 2 are bitwise AND, OR and XOR, and their prefixes match the fold of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | N*W (N elements of W bits) | Input vector; element i is x_in[i] |
| y_out | output | N*W (N elements of W bits) | Prefix results; element i combines inputs i down to 0 |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between x_in and y_out. The bench drives a new vector on the falling clock edge. It samples all outputs one nanosecond later, well before the next rising edge, so each check sees the settled combinational value of that stimulus alone. Eight instances with different element counts (1, 3, 5, 7, 8, 9, 12, 16) and all five operators share each stimulus. Each instance is compared against a sequential fold written in the bench.

// File: rtl/ppn_pkg.sv
package ppn_pkg;

    // Operator encodings used by the prefix network
    typedef enum logic [2:0] {
        OP_AND   = 3'd0,
        OP_OR    = 3'd1,
        OP_XOR   = 3'd2,
        OP_ADD   = 3'd3,
        OP_FIRST = 3'd4   // keep-left: a o b = a (associative, not commutative)
    } op_e;

    // Depth of the recursive network in operator levels (informational)
    function automatic int unsigned ppn_levels(input int unsigned n);
        int unsigned lv;
        int unsigned m;
        lv = 0;
        m  = n;
        while (m > 1) begin
            if (m % 2 == 1) begin
                lv = lv + 1;
                m  = m - 1;
            end else begin
                lv = lv + 2;
                m  = m / 2;
            end
        end
        return lv;
    endfunction

endpackage

// File: rtl/ppn_op_cell.sv
module ppn_op_cell #(
    parameter int unsigned  W  = 8,
    parameter ppn_pkg::op_e OP = ppn_pkg::OP_ADD
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] res
);
    import ppn_pkg::*;

    // One operator instance; lhs is always the higher-indexed operand
    always_comb begin
        case (OP)
            OP_AND:   res = lhs & rhs;
            OP_OR:    res = lhs | rhs;
            OP_XOR:   res = lhs ^ rhs;
            OP_ADD:   res = lhs + rhs;
            default:  res = lhs;
        endcase
    end
endmodule

// File: rtl/ppn_core.sv
module ppn_core #(
    parameter int unsigned  N  = 8,
    parameter int unsigned  W  = 8,
    parameter ppn_pkg::op_e OP = ppn_pkg::OP_ADD
) (
    input  logic [N-1:0][W-1:0] x_in,
    output logic [N-1:0][W-1:0] y_out
);
    localparam bit          IS_ODD = (N % 2) == 1;
    localparam int unsigned HALF   = N / 2;

    generate
        if (N == 1) begin : g_leaf
            assign y_out[0] = x_in[0];
        end else if (IS_ODD) begin : g_odd
            // Network for N-1, then one extra operator on the top element
            logic [N-2:0][W-1:0] y_low;
            ppn_core #(.N(N-1), .W(W), .OP(OP)) u_low (
                .x_in  (x_in[N-2:0]),
                .y_out (y_low)
            );
            assign y_out[N-2:0] = y_low;
            ppn_op_cell #(.W(W), .OP(OP)) u_top (
                .lhs (x_in[N-1]),
                .rhs (y_low[N-2]),
                .res (y_out[N-1])
            );
        end else begin : g_even
            logic [HALF-1:0][W-1:0] pair_v;
            logic [HALF-1:0][W-1:0] half_y;

            // Stage 1: merge adjacent pairs, odd element on the left
            for (genvar i = 0; i < HALF; i++) begin : g_pair
                ppn_op_cell #(.W(W), .OP(OP)) u_pair (
                    .lhs (x_in[2*i+1]),
                    .rhs (x_in[2*i]),
                    .res (pair_v[i])
                );
            end

            // Stage 2: half-size prefix problem
            ppn_core #(.N(HALF), .W(W), .OP(OP)) u_half (
                .x_in  (pair_v),
                .y_out (half_y)
            );

            // Stage 3: odd outputs copied, even outputs fixed up
            for (genvar i = 0; i < HALF; i++) begin : g_fix
                assign y_out[2*i+1] = half_y[i];
                if (i == 0) begin : g_base
                    assign y_out[0] = x_in[0];
                end else begin : g_even_out
                    ppn_op_cell #(.W(W), .OP(OP)) u_fix (
                        .lhs (x_in[2*i]),
                        .rhs (half_y[i-1]),
                        .res (y_out[2*i])
                    );
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ppn_top.sv
module ppn_top #(
    parameter int unsigned  N  = 12,
    parameter int unsigned  W  = 8,
    parameter ppn_pkg::op_e OP = ppn_pkg::OP_ADD
) (
    input  logic [N-1:0][W-1:0] x_in,
    output logic [N-1:0][W-1:0] y_out
);
    import ppn_pkg::*;

    localparam int unsigned LEVELS = ppn_levels(N);

    ppn_core #(.N(N), .W(W), .OP(OP)) u_core (
        .x_in  (x_in),
        .y_out (y_out)
    );

    // Linear-chain reference used only by the assertions below
    logic [N-1:0][W-1:0] chain_ref;
    assign chain_ref[0] = x_in[0];
    generate
        for (genvar i = 1; i < N; i++) begin : g_chk
            ppn_op_cell #(.W(W), .OP(OP)) u_chk (
                .lhs (x_in[i]),
                .rhs (y_out[i-1]),
                .res (chain_ref[i])
            );
        end
    endgenerate

    always_comb begin
        p_base_r2: assert (y_out[0] == x_in[0])
            else $error("y_out[0] differs from x_in[0] (levels=%0d)", LEVELS);
        for (int i = 1; i < N; i++) begin
            p_chain_r1: assert (y_out[i] == chain_ref[i])
                else $error("prefix %0d breaks the recurrence", i);
        end
    end

    generate
        if (OP == OP_FIRST) begin : g_a_first
            always_comb begin
                p_keep_left_r3: assert (y_out == x_in)
                    else $error("keep-left prefix differs from input");
            end
        end
        if (OP == OP_AND) begin : g_a_and
            always_comb begin
                for (int i = 1; i < N; i++) begin
                    p_and_mono_r7: assert ((y_out[i] & ~y_out[i-1]) == '0)
                        else $error("AND prefix %0d gained a bit", i);
                end
            end
        end
        if (OP == OP_OR) begin : g_a_or
            always_comb begin
                for (int i = 1; i < N; i++) begin
                    p_or_mono_r7: assert ((y_out[i-1] & ~y_out[i]) == '0)
                        else $error("OR prefix %0d lost a bit", i);
                end
            end
        end
    endgenerate
endmodule

// File: tb/ppn_top_bench.sv
module ppn_top_bench;
    import ppn_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic [15:0][7:0] xin = '0;

    logic [11:0][7:0] y_a;  // N=12 ADD
    logic [7:0][7:0]  y_b;  // N=8  XOR
    logic [6:0][7:0]  y_c;  // N=7  OR
    logic [4:0][7:0]  y_d;  // N=5  AND
    logic [0:0][7:0]  y_e;  // N=1  ADD
    logic [8:0][7:0]  y_f;  // N=9  keep-left
    logic [15:0][7:0] y_g;  // N=16 ADD
    logic [2:0][7:0]  y_h;  // N=3  XOR

    ppn_top #(.N(12), .W(8), .OP(OP_ADD))   u_ppn_top (.x_in(xin[11:0]), .y_out(y_a));
    ppn_top #(.N(8),  .W(8), .OP(OP_XOR))   u_b (.x_in(xin[7:0]),  .y_out(y_b));
    ppn_top #(.N(7),  .W(8), .OP(OP_OR))    u_c (.x_in(xin[6:0]),  .y_out(y_c));
    ppn_top #(.N(5),  .W(8), .OP(OP_AND))   u_d (.x_in(xin[4:0]),  .y_out(y_d));
    ppn_top #(.N(1),  .W(8), .OP(OP_ADD))   u_e (.x_in(xin[0:0]),  .y_out(y_e));
    ppn_top #(.N(9),  .W(8), .OP(OP_FIRST)) u_f (.x_in(xin[8:0]),  .y_out(y_f));
    ppn_top #(.N(16), .W(8), .OP(OP_ADD))   u_g (.x_in(xin),       .y_out(y_g));
    ppn_top #(.N(3),  .W(8), .OP(OP_XOR))   u_h (.x_in(xin[2:0]),  .y_out(y_h));

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    int cyc    = 0;

    localparam logic [127:0] VEC [8] = '{
        128'h0,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'h0102_0408_1020_4080_0102_0408_1020_4080,
        128'hA5A5_5A5A_A5A5_5A5A_A5A5_5A5A_A5A5_5A5A,
        128'h0F0E_0D0C_0B0A_0908_0706_0504_0302_0100,
        128'h8080_8080_8080_8080_8080_8080_8080_8081,
        128'hDEAD_BEEF_CAFE_F00D_1234_5678_9ABC_DEF0,
        128'h7F3C_E1FF_00FE_C3A9_5511_2B90_6D04_FFEE
    };

    function automatic logic [7:0] op_ref(op_e op, logic [7:0] a, logic [7:0] b);
        case (op)
            OP_AND:  return a & b;
            OP_OR:   return a | b;
            OP_XOR:  return a ^ b;
            OP_ADD:  return 8'(a + b);
            default: return a;
        endcase
    endfunction

    task automatic check_dut(string tag, string name, op_e op, int n, logic [127:0] got);
        logic [7:0] acc;
        logic [7:0] g;
        bit bad;
        bad = 1'b0;
        acc = xin[0];
        for (int i = 0; i < n; i++) begin
            if (i > 0) acc = op_ref(op, xin[i], acc);
            g = got[i*8 +: 8];
            if (!bad && g !== acc) begin
                bad = 1'b1;
                $display("FAIL %s %s y[%0d] actual=%h expected=%h", tag, name, i, g, acc);
            end
        end
        n_run++;
        if (bad) n_fail++;
    endtask

    task automatic check_all();
        check_dut("R1", "n12_add", OP_ADD,   12, 128'(y_a));
        check_dut("R7", "n8_xor",  OP_XOR,   8,  128'(y_b));
        check_dut("R4", "n7_or",   OP_OR,    7,  128'(y_c));
        check_dut("R4", "n5_and",  OP_AND,   5,  128'(y_d));
        check_dut("R5", "n1_add",  OP_ADD,   1,  128'(y_e));
        check_dut("R3", "n9_first",OP_FIRST, 9,  128'(y_f));
        check_dut("R1", "n16_add", OP_ADD,   16, 128'(y_g));
        check_dut("R4", "n3_xor",  OP_XOR,   3,  128'(y_h));
    endtask

    task automatic apply(logic [127:0] v);
        @(negedge clk);
        xin = v;
        #1;
        check_all();
    endtask

    task automatic check_one(string tag, logic [7:0] act, logic [7:0] exp_v);
        n_run++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000 && !done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Idle state: all-zero input gives all-zero prefixes (R1)
        @(negedge clk);
        #1;
        check_one("R1 zero n12", y_a[11], 8'h00);
        check_one("R1 zero n16", y_g[15], 8'h00);

        // Table walk
        for (int k = 0; k < 8; k++) apply(VEC[k]);

        // Random vectors
        for (int k = 0; k < 40; k++)
            apply({$urandom, $urandom, $urandom, $urandom});

        // R6: modulo wrap, all 0xFF -> y[i] = (i+1)*0xFF mod 256
        apply({16{8'hFF}});
        check_one("R6 wrap y[11]", y_a[11], 8'(12 * 255));
        check_one("R6 wrap y[15]", y_g[15], 8'(16 * 255));

        // R2: base output untouched for every operator
        apply({{15{8'h33}}, 8'hC7});
        check_one("R2 n12 y0",  y_a[0], 8'hC7);
        check_one("R2 n5 y0",   y_d[0], 8'hC7);
        check_one("R2 n7 y0",   y_c[0], 8'hC7);

        // R3: keep-left returns each own input
        apply(128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0);
        check_one("R3 first y8", y_f[8], xin[8]);
        check_one("R3 first y5", y_f[5], xin[5]);

        // R4: odd top output, single differing top element
        apply({{9{8'h00}}, 8'h40, {6{8'h01}}});
        check_one("R4 n7 or top", y_c[6], 8'h41);
        check_one("R4 n3 xor top", y_h[2], 8'h01);

        // R7: AND with one clear bit in the middle
        apply({{11{8'hFF}}, 8'hEF, {4{8'hFF}}});
        check_one("R7 n5 and top", y_d[4], 8'hEF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule